// File: doc/BRIEF.md
# Arithmetic and Compare Execution Unit with Condition Bit

This unit is one execution slice of a 16-bit-encoded processor pipeline. In each cycle it may be handed an instruction word and the two 32-bit register values that the word names. It decodes the word against a fixed set of add, compare, divide-setup and multiply encodings. It then produces three things at once: a 32-bit result, a destination index, and a write strobe for the register file. A single condition bit (T) holds the carry, the signed overflow or the compare outcome, depending on the operation. Two further bits (M and Q) hold the divide-setup state.

All operations except the multiplies finish in the cycle they are presented. A 32x32 multiply, signed or unsigned, occupies the unit for a parameterised number of cycles (2 to 4). The unit raises `busy` for that time and ignores new instructions while it is high. It then writes the 64-bit product into a high/low accumulator pair. Operand fetch and register storage belong to the surrounding pipeline. For the immediate-against-R0 compare, the pipeline places R0 on `opa`. Words that match no supported encoding are flagged through `illegal`.

Top module: `arith_tunit`

## Requirements
- R1: After synchronous reset, `t_flag`, `m_bit`, `q_bit`, `busy`, `acc_hi` and `acc_lo` are all zero.
- R2: Word `0011nnnnmmmm1100` writes `opa+opb`. Word `0111nnnniiiiiiii` writes `opa` plus the sign-extended 8-bit immediate. Both assert `res_we` with `dst_idx` equal to word bits [11:8] and leave T unchanged.
- R3: Word `0011nnnnmmmm1110` writes `opa+opb+T` and loads T with the carry out of bit 31.
- R4: Word `0011nnnnmmmm1111` writes `opa+opb` and loads T with 1 exactly when the two's-complement sum overflows.
- R5: Words `0011nnnnmmmmxxxx` with xxxx = 0000, 0010, 0011, 0110, 0111 set T to the respective test (opa==opb; unsigned >=; signed >=; unsigned >; signed >) and deassert `res_we`.
- R6: Word `10001000iiiiiiii` sets T when `opa` equals the sign-extended immediate. Word `0100nnnn00010101` sets T when `opa` is signed greater than zero. Word `0100nnnn00010001` sets T when `opa` is signed non-negative. None of the three writes a register.
- R7: Word `0010nnnnmmmm1100` sets T when at least one of the four byte lanes of `opa` equals the same lane of `opb`, and writes no register.
- R8: Word `0010nnnnmmmm0111` loads Q with `opa[31]`, M with `opb[31]`, and T with their XOR. Word `0000000000011001` clears T, M and Q. Neither writes a register.
- R9: Word `0011nnnnmmmm1101` (signed) and word `0011nnnnmmmm0101` (unsigned) put the 64-bit product of `opa` and `opb` into `{acc_hi, acc_lo}` and leave T unchanged. After the accepting edge, `busy` stays high for exactly MUL_LAT-1 cycles and falls at the edge that writes the product.
- R10: While `busy` is high, a presented instruction is ignored: `res_we` and `illegal` stay low and T, M and Q keep their values.
- R11: Any other word (for example `0011nnnnmmmm0001`) drives `illegal` high in the cycle it is presented, writes no register and leaves T, M and Q unchanged.
- R12: Every non-multiply operation presents `res`, `res_we` and `illegal` combinationally in the cycle of the word, updates T/M/Q at the next clock edge, and never raises `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | An instruction word is presented this cycle |
| insn | input | 16 | Instruction word |
| opa | input | 32 | Value of register n (R0 for the immediate compare) |
| opb | input | 32 | Value of register m |
| res | output | 32 | Result value for the destination register |
| res_we | output | 1 | Destination register write strobe |
| dst_idx | output | 4 | Destination register index (word bits [11:8]) |
| illegal | output | 1 | Presented word is not a supported encoding |
| t_flag | output | 1 | Current condition bit |
| m_bit | output | 1 | Current divide-setup M bit |
| q_bit | output | 1 | Current divide-setup Q bit |
| busy | output | 1 | Multiply in progress; new words are ignored |
| acc_hi | output | 32 | Upper half of the multiply accumulator |
| acc_lo | output | 32 | Lower half of the multiply accumulator |

## Verification
The hardest case to reach from the ports is an instruction that arrives while a multiply is still in flight. If the unit accepted it, the word would silently change T or fire a write strobe. To exercise this, the stimulus presents a word in every busy cycle: an add-with-carry whose operands would flip T, and an unsupported encoding. It then checks that the strobes stay low and that T is untouched. The carry chain through T is also exercised, because random sequences let add-with-carry consume T values left by earlier compares, setups and overflows.

// File: rtl/arith_pkg.sv
package arith_pkg;
    localparam int XLEN  = 32;
    localparam int ILEN  = 16;
    localparam int RIDX  = 4;
    localparam int IMMW  = 8;
    localparam int LANES = XLEN / 8;

    typedef enum logic [4:0] {
        OP_ADD, OP_ADDI, OP_ADDC, OP_ADDV,
        OP_CMPEQ, OP_CMPHS, OP_CMPGE, OP_CMPHI, OP_CMPGT,
        OP_CMPIM, OP_CMPPL, OP_CMPPZ, OP_CMPSTR,
        OP_DSETS, OP_DSETU, OP_MULS, OP_MULU, OP_BAD
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [RIDX-1:0]  rd;
        logic [XLEN-1:0]  imm;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            we;
        logic            t;
        logic            m;
        logic            q;
    } exe_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic logic is_compare(input op_e op);
        return op inside {OP_CMPEQ, OP_CMPHS, OP_CMPGE, OP_CMPHI, OP_CMPGT,
                          OP_CMPIM, OP_CMPPL, OP_CMPPZ, OP_CMPSTR};
    endfunction
endpackage

// File: rtl/arith_decode.sv
module arith_decode
    import arith_pkg::*;
(
    input  logic [ILEN-1:0] insn,
    output dec_t            dec
);
    always_comb begin
        dec.rd  = insn[11:8];
        dec.imm = sext_imm(insn[IMMW-1:0]);
        casez (insn)
            16'b0011_????_????_1100: dec.op = OP_ADD;
            16'b0111_????_????_????: dec.op = OP_ADDI;
            16'b0011_????_????_1110: dec.op = OP_ADDC;
            16'b0011_????_????_1111: dec.op = OP_ADDV;
            16'b0011_????_????_0000: dec.op = OP_CMPEQ;
            16'b0011_????_????_0010: dec.op = OP_CMPHS;
            16'b0011_????_????_0011: dec.op = OP_CMPGE;
            16'b0011_????_????_0110: dec.op = OP_CMPHI;
            16'b0011_????_????_0111: dec.op = OP_CMPGT;
            16'b1000_1000_????_????: dec.op = OP_CMPIM;
            16'b0100_????_0001_0101: dec.op = OP_CMPPL;
            16'b0100_????_0001_0001: dec.op = OP_CMPPZ;
            16'b0010_????_????_1100: dec.op = OP_CMPSTR;
            16'b0010_????_????_0111: dec.op = OP_DSETS;
            16'b0000_0000_0001_1001: dec.op = OP_DSETU;
            16'b0011_????_????_1101: dec.op = OP_MULS;
            16'b0011_????_????_0101: dec.op = OP_MULU;
            default:                 dec.op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/arith_exec.sv
module arith_exec
    import arith_pkg::*;
(
    input  op_e             op,
    input  logic [XLEN-1:0] imm,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            t_in,
    input  logic            m_in,
    input  logic            q_in,
    output exe_t            out
);
    logic [LANES-1:0] lane_eq;
    logic [XLEN:0]    sum;
    logic [XLEN:0]    sum_c;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (opa[8*g +: 8] == opb[8*g +: 8]);
    end

    always_comb begin
        sum   = {1'b0, opa} + {1'b0, opb};
        sum_c = sum + {{XLEN{1'b0}}, t_in};
        out.value = sum[XLEN-1:0];
        out.we    = 1'b0;
        out.t     = t_in;
        out.m     = m_in;
        out.q     = q_in;
        case (op)
            OP_ADD:  out.we = 1'b1;
            OP_ADDI: begin
                out.value = opa + imm;
                out.we    = 1'b1;
            end
            OP_ADDC: begin
                out.value = sum_c[XLEN-1:0];
                out.t     = sum_c[XLEN];
                out.we    = 1'b1;
            end
            OP_ADDV: begin
                out.we = 1'b1;
                out.t  = (opa[XLEN-1] == opb[XLEN-1]) && (sum[XLEN-1] != opa[XLEN-1]);
            end
            OP_CMPEQ:  out.t = (opa == opb);
            OP_CMPHS:  out.t = (opa >= opb);
            OP_CMPGE:  out.t = ($signed(opa) >= $signed(opb));
            OP_CMPHI:  out.t = (opa > opb);
            OP_CMPGT:  out.t = ($signed(opa) > $signed(opb));
            OP_CMPIM:  out.t = (opa == imm);
            OP_CMPPL:  out.t = !opa[XLEN-1] && (|opa);
            OP_CMPPZ:  out.t = !opa[XLEN-1];
            OP_CMPSTR: out.t = |lane_eq;
            OP_DSETS: begin
                out.q = opa[XLEN-1];
                out.m = opb[XLEN-1];
                out.t = opa[XLEN-1] ^ opb[XLEN-1];
            end
            OP_DSETU: begin
                out.q = 1'b0;
                out.m = 1'b0;
                out.t = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/arith_mul.sv
module arith_mul
    import arith_pkg::*;
#(
    parameter int MUL_LAT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            signed_op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            busy,
    output logic [XLEN-1:0] acc_hi,
    output logic [XLEN-1:0] acc_lo
);
    localparam int CNT_W = (MUL_LAT > 2) ? $clog2(MUL_LAT) : 1;

    logic [XLEN-1:0]   a_q, b_q;
    logic              sgn_q;
    logic [CNT_W-1:0]  cnt;
    logic signed [XLEN:0] xa, xb;
    logic [2*XLEN-1:0] prod;

    assign xa   = $signed({sgn_q & a_q[XLEN-1], a_q});
    assign xb   = $signed({sgn_q & b_q[XLEN-1], b_q});
    assign prod = (2*XLEN)'(xa) * (2*XLEN)'(xb);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            a_q    <= '0;
            b_q    <= '0;
            sgn_q  <= 1'b0;
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (busy) begin
            if (cnt == '0) begin
                busy             <= 1'b0;
                {acc_hi, acc_lo} <= prod;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= CNT_W'(MUL_LAT - 2);
            a_q   <= a;
            b_q   <= b;
            sgn_q <= signed_op;
        end
    end

    logic [CNT_W:0] run;
    always_ff @(posedge clk) begin
        if (rst)       run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    // R9
    mul_busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R9
    mul_busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run <= (CNT_W+1)'(MUL_LAT - 2)));
    // R9
    mul_busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && run == (CNT_W+1)'(MUL_LAT - 2)) |=> !busy);

    initial begin
        assert (MUL_LAT >= 2 && MUL_LAT <= 4);
    end
endmodule

// File: rtl/arith_tunit.sv
module arith_tunit
    import arith_pkg::*;
#(
    parameter int MUL_LAT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            insn_valid,
    input  logic [15:0]     insn,
    input  logic [31:0]     opa,
    input  logic [31:0]     opb,
    output logic [31:0]     res,
    output logic            res_we,
    output logic [3:0]      dst_idx,
    output logic            illegal,
    output logic            t_flag,
    output logic            m_bit,
    output logic            q_bit,
    output logic            busy,
    output logic [31:0]     acc_hi,
    output logic [31:0]     acc_lo
);
    dec_t dec;
    exe_t exe;
    logic go;
    logic mul_go;

    arith_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    arith_exec u_exe (
        .op   (dec.op),
        .imm  (dec.imm),
        .opa  (opa),
        .opb  (opb),
        .t_in (t_flag),
        .m_in (m_bit),
        .q_in (q_bit),
        .out  (exe)
    );

    assign go      = insn_valid && !busy;
    assign mul_go  = go && (dec.op == OP_MULS || dec.op == OP_MULU);
    assign res     = exe.value;
    assign res_we  = go && exe.we;
    assign dst_idx = dec.rd;
    assign illegal = go && (dec.op == OP_BAD);

    arith_mul #(.MUL_LAT(MUL_LAT)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .start     (mul_go),
        .signed_op (dec.op == OP_MULS),
        .a         (opa),
        .b         (opb),
        .busy      (busy),
        .acc_hi    (acc_hi),
        .acc_lo    (acc_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            t_flag <= 1'b0;
            m_bit  <= 1'b0;
            q_bit  <= 1'b0;
        end else if (go && dec.op != OP_BAD) begin
            t_flag <= exe.t;
            m_bit  <= exe.m;
            q_bit  <= exe.q;
        end
    end

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!res_we && !illegal));
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (t_flag == $past(t_flag) && m_bit == $past(m_bit) && q_bit == $past(q_bit)));
    // R5
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (go && is_compare(dec.op)) |-> !res_we);
    // R2
    add_keeps_t_chk: assert property (@(posedge clk) disable iff (rst)
        (go && (dec.op == OP_ADD || dec.op == OP_ADDI)) |=> (t_flag == $past(t_flag)));
    // R8
    dsetu_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (go && dec.op == OP_DSETU) |=> (!t_flag && !m_bit && !q_bit));
    // R11
    illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |=> (t_flag == $past(t_flag) && m_bit == $past(m_bit) && q_bit == $past(q_bit)));
    // R11
    illegal_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !res_we);
    // R12
    single_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !mul_go) |=> !busy);
endmodule

// File: tb/arith_tunit_test.sv
module arith_tunit_test;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        insn_valid;
    logic [15:0] insn;
    logic [31:0] opa, opb;
    logic [31:0] res;
    logic        res_we;
    logic [3:0]  dst_idx;
    logic        illegal;
    logic        t_flag, m_bit, q_bit, busy;
    logic [31:0] acc_hi, acc_lo;

    int total = 0;
    int bad   = 0;
    logic mt = 1'b0, mm = 1'b0, mq = 1'b0;

    always #5 clk = ~clk;

    arith_tunit #(.MUL_LAT(LAT)) uut (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn),
        .opa(opa), .opb(opb), .res(res), .res_we(res_we), .dst_idx(dst_idx),
        .illegal(illegal), .t_flag(t_flag), .m_bit(m_bit), .q_bit(q_bit),
        .busy(busy), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic predict(input logic [15:0] i, input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] v, output logic we, output logic ill,
                           output logic ismul, output logic [63:0] prod, output string tag);
        logic [32:0] s;
        logic [31:0] imm;
        longint sa, sb;
        imm = {{24{i[7]}}, i[7:0]};
        s = {1'b0, a} + {1'b0, b};
        v = s[31:0]; we = 0; ill = 0; ismul = 0; prod = 0; tag = "R5";
        casez (i)
            16'b0011_????_????_1100: begin we = 1; tag = "R2"; end
            16'b0111_????_????_????: begin v = a + imm; we = 1; tag = "R2"; end
            16'b0011_????_????_1110: begin
                s = {1'b0, a} + {1'b0, b} + {32'd0, mt};
                v = s[31:0]; we = 1; mt = s[32]; tag = "R3";
            end
            16'b0011_????_????_1111: begin
                we = 1; tag = "R4";
                mt = (a[31] == b[31]) && (v[31] != a[31]);
            end
            16'b0011_????_????_0000: mt = (a == b);
            16'b0011_????_????_0010: mt = (a >= b);
            16'b0011_????_????_0011: mt = ($signed(a) >= $signed(b));
            16'b0011_????_????_0110: mt = (a > b);
            16'b0011_????_????_0111: mt = ($signed(a) > $signed(b));
            16'b1000_1000_????_????: begin mt = (a == imm); tag = "R6"; end
            16'b0100_????_0001_0101: begin mt = ($signed(a) > 0); tag = "R6"; end
            16'b0100_????_0001_0001: begin mt = ($signed(a) >= 0); tag = "R6"; end
            16'b0010_????_????_1100: begin
                tag = "R7";
                mt = (a[7:0] == b[7:0]) || (a[15:8] == b[15:8]) ||
                     (a[23:16] == b[23:16]) || (a[31:24] == b[31:24]);
            end
            16'b0010_????_????_0111: begin mq = a[31]; mm = b[31]; mt = a[31] ^ b[31]; tag = "R8"; end
            16'b0000_0000_0001_1001: begin mq = 0; mm = 0; mt = 0; tag = "R8"; end
            16'b0011_????_????_1101: begin
                ismul = 1; tag = "R9";
                sa = longint'($signed(a)); sb = longint'($signed(b));
                prod = 64'(sa * sb);
            end
            16'b0011_????_????_0101: begin
                ismul = 1; tag = "R9";
                prod = {32'd0, a} * {32'd0, b};
            end
            default: begin ill = 1; tag = "R11"; end
        endcase
    endtask

    task automatic issue(input logic [15:0] i, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] v; logic we, ill, ismul; logic [63:0] prod; string tag;
        int n;
        @(negedge clk);
        insn_valid = 1; insn = i; opa = a; opb = b;
        #1;
        predict(i, a, b, v, we, ill, ismul, prod, tag);
        chk(tag, "res_we", {63'd0, res_we}, {63'd0, we});
        chk(tag, "illegal", {63'd0, illegal}, {63'd0, ill});
        if (we) begin
            chk(tag, "res", {32'd0, res}, {32'd0, v});
            chk(tag, "dst_idx", {60'd0, dst_idx}, {60'd0, i[11:8]});
        end
        @(posedge clk); #1;
        insn_valid = 0;
        chk(tag, "t_flag", {63'd0, t_flag}, {63'd0, mt});
        chk(tag, "m/q", {62'd0, m_bit, q_bit}, {62'd0, mm, mq});
        if (!ismul) begin
            // R12: single-cycle ops never raise busy
            chk("R12", "busy", {63'd0, busy}, 64'd0);
        end else begin
            n = 0;
            while (busy && n < 20) begin
                @(negedge clk);
                insn_valid = 1;
                insn = n[0] ? 16'h3011 : 16'h312E;
                opa = 32'hFFFF_FFFF; opb = 32'h0000_0001;
                #1;
                // R10: words during busy are ignored
                chk("R10", "res_we busy", {63'd0, res_we}, 64'd0);
                chk("R10", "illegal busy", {63'd0, illegal}, 64'd0);
                @(posedge clk); #1;
                n++;
            end
            insn_valid = 0;
            chk("R10", "t held", {63'd0, t_flag}, {63'd0, mt});
            chk("R9", "busy cycles", 64'(n), 64'(LAT - 1));
            chk("R9", "product", {acc_hi, acc_lo}, prod);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        logic [15:0] w;
        logic [3:0] n, m;
        logic [7:0] im;
        int k;
        void'($urandom(32'd7141));
        rst = 1; insn_valid = 0; insn = 0; opa = 0; opb = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "flags", {61'd0, t_flag, m_bit, q_bit}, 64'd0);
        chk("R1", "busy", {63'd0, busy}, 64'd0);
        chk("R1", "acc", {acc_hi, acc_lo}, 64'd0);
        @(negedge clk); rst = 0;

        // directed corner cases
        issue(16'h325C, 32'd10, 32'd20);                  // R2 add
        issue(16'h70FF, 32'd5, 32'd0);                    // R2 add imm -1
        issue(16'h3120, 32'h8000_0000, 32'h8000_0000);    // R5 equal
        issue(16'h312E, 32'hFFFF_FFFF, 32'h0000_0000);    // R3 carry-in 1 -> carry out
        issue(16'h312E, 32'h0000_0001, 32'h0000_0001);    // R3 clear carry
        issue(16'h312F, 32'h7FFF_FFFF, 32'h0000_0001);    // R4 overflow
        issue(16'h3122, 32'h8000_0000, 32'h0000_0001);    // R5 unsigned >=
        issue(16'h3123, 32'h8000_0000, 32'h0000_0001);    // R5 signed >=
        issue(16'h3126, 32'h0000_0005, 32'h0000_0005);    // R5 unsigned > equal
        issue(16'h3127, 32'h0000_0001, 32'hFFFF_FFFF);    // R5 signed >
        issue(16'h88F0, 32'hFFFF_FFF0, 32'd0);            // R6 imm compare sign-extended
        issue(16'h4315, 32'd0, 32'd0);                    // R6 >0 on zero
        issue(16'h4311, 32'd0, 32'd0);                    // R6 >=0 on zero
        issue(16'h212C, 32'h1122_3344, 32'hAA22_BBCC);    // R7 one lane equal
        issue(16'h212C, 32'h1122_3344, 32'h2233_4455);    // R7 no lane
        issue(16'h2127, 32'h8000_0000, 32'h0000_0001);    // R8 signed setup
        issue(16'h0019, 32'd0, 32'd0);                    // R8 unsigned setup
        issue(16'h312D, 32'hFFFF_FFFE, 32'd3);            // R9 signed
        issue(16'h3125, 32'hFFFF_FFFF, 32'hFFFF_FFFF);    // R9 unsigned
        issue(16'h3001, 32'd1, 32'd2);                    // R11
        issue(16'hFFFF, 32'd1, 32'd2);                    // R11

        for (int it = 0; it < 400; it++) begin
            n = 4'($urandom); m = 4'($urandom); im = 8'($urandom);
            a = $urandom;
            case ($urandom % 5)
                0: b = a;
                1: b = a ^ (32'hFF << (8 * ($urandom % 4)));
                2: b = $urandom & 32'h1FF;
                3: begin a = $urandom % 3 == 0 ? 32'd0 : a; b = $urandom; end
                default: b = $urandom;
            endcase
            k = $urandom % 18;
            case (k)
                0:  w = {4'h3, n, m, 4'hC};
                1:  w = {4'h7, n, im};
                2:  w = {4'h3, n, m, 4'hE};
                3:  w = {4'h3, n, m, 4'hF};
                4:  w = {4'h3, n, m, 4'h0};
                5:  w = {4'h3, n, m, 4'h2};
                6:  w = {4'h3, n, m, 4'h3};
                7:  w = {4'h3, n, m, 4'h6};
                8:  w = {4'h3, n, m, 4'h7};
                9:  begin w = {8'h88, im}; if (im[0]) a = {{24{im[7]}}, im}; end
                10: w = {4'h4, n, 8'h15};
                11: w = {4'h4, n, 8'h11};
                12: w = {4'h2, n, m, 4'hC};
                13: w = {4'h2, n, m, 4'h7};
                14: w = 16'h0019;
                15: w = {4'h3, n, m, 4'hD};
                16: w = {4'h3, n, m, 4'h5};
                default: w = {4'h3, n, m, 4'h1};
            endcase
            issue(w, a, b);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule